// File: doc/BRIEF.md
# Pipeline Activity Idle Detector

This block tells a pipelined processor whether it still has outstanding work, so that clocks can be gated or the core put to sleep without losing anything in flight. It keeps one bit per cycle of the longest inter-stage latency in a shift register that steps with the pipeline's own time buffers. Each cycle in which any stage writes a time buffer, the producer pulses the activity strobe, which marks the newest slot. It also keeps one active flag per pipeline stage, which stages raise and drop through activate and deactivate requests.

One occupancy counter covers both kinds of work. It rises when an empty slot gets marked or an inactive stage turns on. It falls when a marked slot leaves the oldest position or an active stage turns off. A zero counter means the core may idle, so the idle decision is one compare on a registered value. Software-style control is limited to a synchronous clear and a preset load. The preset can seed the counter with a large value so that idling is held off. A consistency output compares the counter against the real number of marked slots plus raised flags whenever no preset has been loaded.

All state is registered. Outputs show the effect of an input cycle right after the clock edge that samples it.

Top module: `pipe_idle_detect`

## Requirements
- R1: After reset or a cycle with `clear` high, `activityCount` is 0 and `isActive` is 0. All slots are empty and all stage flags are down. `clear` overrides every other input in that cycle.
- R2: `actStrobe` sets slot 0, the newest slot. The counter rises by one only if slot 0 held 0 at that point. A strobe repeated without `advance` leaves the counter unchanged.
- R3: `advance` moves each slot one position toward slot LATENCY-1. A 1 leaving slot LATENCY-1 lowers the counter by one, so a single strobe is counted for exactly LATENCY advances.
- R4: When `advance` and `actStrobe` share a cycle, the shift happens first. The strobe then lands in the emptied slot 0 and always adds one.
- R5: An activate request (bit i of `stageActivate`) for an inactive stage raises its flag and adds one. A deactivate request (bit i of `stageDeactivate`) for an active stage drops its flag and subtracts one.
- R6: Ignored requests leave both the flag and the counter unchanged. This covers activate for an already active stage, deactivate for an inactive stage, and activate plus deactivate for the same stage in one cycle.
- R7: All increments and decrements of one cycle are summed into a single net change.
- R8: `isActive` is 1 exactly when `activityCount` is nonzero.
- R9: `presetLoad` (without `clear`) writes `presetValue` into the counter, and this overrides that cycle's net change. Slots and flags still update, and later cycles adjust the counter from the preset value.
- R10: The counter saturates. It never goes below 0 and never wraps past its all-ones value of 2^CNT_W - 1.
- R11: `countMismatch` is 0 while no preset has been loaded since the last reset or clear. Once a preset has been loaded, it is 1 whenever the counter differs from the number of set slots plus raised stage flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of slots, flags, counter and preset marker |
| presetLoad | input | 1 | Load `presetValue` into the counter |
| presetValue | input | CNT_W | Counter preset value |
| actStrobe | input | 1 | Time-buffer write happened this cycle |
| advance | input | 1 | Pipeline time buffers advance this cycle |
| stageActivate | input | NUM_STAGES | Per-stage activate requests |
| stageDeactivate | input | NUM_STAGES | Per-stage deactivate requests |
| activityCount | output | CNT_W | Occupancy counter |
| isActive | output | 1 | Counter is nonzero; the core must not idle |
| countMismatch | output | 1 | Counter differs from real occupancy after a preset |

## Verification
The assertions assume that `advance` is pulsed in step with the pipeline's time buffers and that no one changes the counter except through this block's inputs. Under those conditions the counter always equals the popcount of slots plus flags until a preset is loaded. The saturation property also assumes that the top value is reached only through a preset, because the counter is sized with headroom above the largest possible real occupancy. The stimulus keeps to these assumptions. It drives every input a step after the active edge and reaches the counter limits only through `presetLoad`. It also clears the block before each lifetime test, so every expected count follows from the inputs alone.

// File: rtl/pipe_idle_pkg.sv
package pipe_idle_pkg;

  // Strobes from control to datapath, already prioritised
  typedef struct packed {
    logic clr;    // wipe slots, flags, counter
    logic load;   // preset counter (clear not active)
    logic shift;  // advance slots
    logic mark;   // set newest slot
  } idleStrobes_t;

endpackage

// File: rtl/idle_ctrl.sv
module idle_ctrl
  import pipe_idle_pkg::*;
(
  input  logic         clear,
  input  logic         presetLoad,
  input  logic         actStrobe,
  input  logic         advance,
  output idleStrobes_t strobes
);

  // clear dominates; load and slot updates may coexist
  always_comb begin
    strobes.clr   = clear;
    strobes.load  = presetLoad & ~clear;
    strobes.shift = advance & ~clear;
    strobes.mark  = actStrobe & ~clear;
  end

endmodule

// File: rtl/idle_stage_flags.sv
module idle_stage_flags #(
  parameter int NUM_STAGES = 4,
  localparam int SW = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [NUM_STAGES-1:0] actReq,
  input  logic [NUM_STAGES-1:0] deactReq,
  output logic [NUM_STAGES-1:0] flags,
  output logic [SW-1:0]         incCnt,
  output logic [SW-1:0]         decCnt
);

  logic [NUM_STAGES-1:0] turnOn;
  logic [NUM_STAGES-1:0] turnOff;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    // only real transitions count; conflicting requests are dropped
    assign turnOn[i]  = actReq[i] & ~deactReq[i] & ~flags[i];
    assign turnOff[i] = deactReq[i] & ~actReq[i] & flags[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (clr)        flags[i] <= 1'b0;
      else if (turnOn[i])  flags[i] <= 1'b1;
      else if (turnOff[i]) flags[i] <= 1'b0;
    end

    // R5: an activate on an idle stage raises its flag
    assert_stage_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && actReq[i] && !deactReq[i]) |=> flags[i]);

    // R6: a deactivate on an inactive stage keeps it down
    assert_stage_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !flags[i] && !actReq[i]) |=> !flags[i]);
  end

  always_comb begin
    incCnt = '0;
    decCnt = '0;
    for (int k = 0; k < NUM_STAGES; k++) begin
      incCnt = incCnt + SW'(turnOn[k]);
      decCnt = decCnt + SW'(turnOff[k]);
    end
  end

endmodule

// File: rtl/idle_datapath.sv
module idle_datapath
  import pipe_idle_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int LATENCY    = 4,
  parameter int CNT_W      = 6,
  localparam int SW        = $clog2(NUM_STAGES + 1),
  localparam int SUM_W     = CNT_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  idleStrobes_t          strobes,
  input  logic [CNT_W-1:0]      presetValue,
  input  logic [NUM_STAGES-1:0] flags,
  input  logic [SW-1:0]         stageInc,
  input  logic [SW-1:0]         stageDec,
  output logic [CNT_W-1:0]      count,
  output logic                  mismatch
);

  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  logic [LATENCY-1:0] slots;
  logic [LATENCY-1:0] slotsShifted;
  logic [LATENCY-1:0] slotsNext;
  logic               slotInc;
  logic               slotDec;
  logic               presetSeen;
  logic [SUM_W-1:0]   upSum;
  logic [SUM_W-1:0]   downSum;
  logic [SUM_W-1:0]   netSum;
  logic [CNT_W-1:0]   countNext;
  logic [CNT_W-1:0]   occupancy;

  // shift first, then mark the emptied newest slot
  always_comb begin
    slotsShifted = strobes.shift ? (slots << 1) : slots;
    slotDec      = strobes.shift & slots[LATENCY-1];
    slotInc      = strobes.mark & ~slotsShifted[0];
    slotsNext    = slotsShifted | LATENCY'(strobes.mark);
  end

  // net change with saturation at both ends
  always_comb begin
    upSum   = SUM_W'(count) + SUM_W'(slotInc) + SUM_W'(stageInc);
    downSum = SUM_W'(slotDec) + SUM_W'(stageDec);
    if (upSum < downSum) netSum = '0;
    else                 netSum = upSum - downSum;
    if (netSum > CNT_MAX) countNext = CNT_MAX[CNT_W-1:0];
    else                  countNext = netSum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots      <= '0;
      count      <= '0;
      presetSeen <= 1'b0;
    end else if (strobes.clr) begin
      slots      <= '0;
      count      <= '0;
      presetSeen <= 1'b0;
    end else begin
      slots <= slotsNext;
      if (strobes.load) begin
        count      <= presetValue;
        presetSeen <= 1'b1;
      end else begin
        count <= countNext;
      end
    end
  end

  // real occupancy for the consistency output
  always_comb begin
    occupancy = '0;
    for (int k = 0; k < LATENCY; k++)    occupancy = occupancy + CNT_W'(slots[k]);
    for (int k = 0; k < NUM_STAGES; k++) occupancy = occupancy + CNT_W'(flags[k]);
  end

  assign mismatch = presetSeen && (count != occupancy);

  // R1: clear empties everything on the next edge
  assert_clear_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clr |=> (count == '0 && slots == '0));

  // R2: a strobe always leaves the newest slot set
  assert_mark_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.mark |=> slots[0]);

  // R3: shifting carries slot 0 into slot 1
  if (LATENCY > 1) begin : g_shiftChk
    assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes.shift && !strobes.clr) |=> (slots[1] == $past(slots[0])));
  end

  // R9: a preset lands verbatim
  assert_preset_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (count == $past(presetValue)));

  // R10: the top value never wraps over
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX[CNT_W-1:0] && !strobes.clr && !strobes.load &&
     !slotDec && stageDec == '0) |=> (count == CNT_MAX[CNT_W-1:0]));

  // R11: counter matches real occupancy until a preset is taken
  assert_consistent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !presetSeen |-> (count == occupancy));

endmodule

// File: rtl/pipe_idle_detect.sv
module pipe_idle_detect
  import pipe_idle_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int LATENCY    = 4,
  parameter int HEADROOM   = 2,
  localparam int CNT_W     = $clog2(NUM_STAGES + LATENCY + 1) + HEADROOM,
  localparam int SW        = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  presetLoad,
  input  logic [CNT_W-1:0]      presetValue,
  input  logic                  actStrobe,
  input  logic                  advance,
  input  logic [NUM_STAGES-1:0] stageActivate,
  input  logic [NUM_STAGES-1:0] stageDeactivate,
  output logic [CNT_W-1:0]      activityCount,
  output logic                  isActive,
  output logic                  countMismatch
);

  idleStrobes_t          strobes;
  logic [NUM_STAGES-1:0] flags;
  logic [SW-1:0]         stageInc;
  logic [SW-1:0]         stageDec;

  idle_ctrl u_ctrl (
    .clear      (clear),
    .presetLoad (presetLoad),
    .actStrobe  (actStrobe),
    .advance    (advance),
    .strobes    (strobes)
  );

  idle_stage_flags #(.NUM_STAGES(NUM_STAGES)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (strobes.clr),
    .actReq   (stageActivate),
    .deactReq (stageDeactivate),
    .flags    (flags),
    .incCnt   (stageInc),
    .decCnt   (stageDec)
  );

  idle_datapath #(
    .NUM_STAGES (NUM_STAGES),
    .LATENCY    (LATENCY),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .presetValue (presetValue),
    .flags       (flags),
    .stageInc    (stageInc),
    .stageDec    (stageDec),
    .count       (activityCount),
    .mismatch    (countMismatch)
  );

  assign isActive = |activityCount;

endmodule

// File: tb/pipe_idle_detect_test.sv
`timescale 1ns/1ps
module pipe_idle_detect_test;

  localparam int NS = 4;
  localparam int LAT = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          presetLoad = 1'b0;
  logic [CW-1:0] presetValue = '0;
  logic          actStrobe = 1'b0;
  logic          advance = 1'b0;
  logic [NS-1:0] stageActivate = '0;
  logic [NS-1:0] stageDeactivate = '0;
  logic [CW-1:0] activityCount;
  logic          isActive;
  logic          countMismatch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pipe_idle_detect #(.NUM_STAGES(NS), .LATENCY(LAT), .HEADROOM(2)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .presetLoad(presetLoad),
    .presetValue(presetValue), .actStrobe(actStrobe), .advance(advance),
    .stageActivate(stageActivate), .stageDeactivate(stageDeactivate),
    .activityCount(activityCount), .isActive(isActive),
    .countMismatch(countMismatch)
  );

  typedef struct packed {
    logic          clr;
    logic          ld;
    logic [CW-1:0] pv;
    logic          mk;
    logic          adv;
    logic [NS-1:0] act;
    logic [NS-1:0] de;
    logic [CW-1:0] expCnt;
    logic          expMis;
  } vec_t;

  localparam int NV = 24;
  // clr ld pv mk adv act de exp mis
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,6'd0, 1'b1,1'b0,4'b0000,4'b0000,6'd1, 1'b0}, // 0  R2 mark
    '{1'b0,1'b0,6'd0, 1'b1,1'b0,4'b0000,4'b0000,6'd1, 1'b0}, // 1  R2 repeat
    '{1'b0,1'b0,6'd0, 1'b0,1'b1,4'b0000,4'b0000,6'd1, 1'b0}, // 2  R3 shift
    '{1'b0,1'b0,6'd0, 1'b1,1'b1,4'b0000,4'b0000,6'd2, 1'b0}, // 3  R4 shift+mark
    '{1'b0,1'b0,6'd0, 1'b0,1'b0,4'b0001,4'b0000,6'd3, 1'b0}, // 4  R5 on
    '{1'b0,1'b0,6'd0, 1'b0,1'b0,4'b0001,4'b0000,6'd3, 1'b0}, // 5  R6 re-on
    '{1'b0,1'b0,6'd0, 1'b0,1'b0,4'b0000,4'b0010,6'd3, 1'b0}, // 6  R6 off idle
    '{1'b0,1'b0,6'd0, 1'b0,1'b0,4'b0010,4'b0010,6'd3, 1'b0}, // 7  R6 conflict
    '{1'b0,1'b0,6'd0, 1'b0,1'b1,4'b0000,4'b0000,6'd3, 1'b0}, // 8  R3
    '{1'b0,1'b0,6'd0, 1'b0,1'b1,4'b0000,4'b0001,6'd1, 1'b0}, // 9  R7 two decs
    '{1'b0,1'b0,6'd0, 1'b1,1'b1,4'b0110,4'b0000,6'd4, 1'b0}, // 10 R7 mixed
    '{1'b0,1'b0,6'd0, 1'b0,1'b1,4'b0000,4'b0000,6'd3, 1'b0}, // 11 R3 exit
    '{1'b0,1'b0,6'd0, 1'b0,1'b1,4'b0000,4'b0000,6'd3, 1'b0}, // 12
    '{1'b0,1'b0,6'd0, 1'b0,1'b1,4'b0000,4'b0000,6'd3, 1'b0}, // 13
    '{1'b0,1'b0,6'd0, 1'b0,1'b1,4'b0000,4'b0000,6'd2, 1'b0}, // 14 R3 exit
    '{1'b0,1'b0,6'd0, 1'b0,1'b0,4'b0000,4'b0110,6'd0, 1'b0}, // 15 R5 R8 idle
    '{1'b0,1'b1,6'd50,1'b0,1'b0,4'b0000,4'b0000,6'd50,1'b1}, // 16 R9 preset
    '{1'b0,1'b0,6'd0, 1'b0,1'b0,4'b1111,4'b0000,6'd54,1'b1}, // 17 R9 from preset
    '{1'b1,1'b1,6'd9, 1'b0,1'b0,4'b0000,4'b0000,6'd0, 1'b0}, // 18 R1 clear wins
    '{1'b0,1'b1,6'd0, 1'b0,1'b0,4'b0011,4'b0000,6'd0, 1'b1}, // 19 R9 load wins
    '{1'b0,1'b0,6'd0, 1'b0,1'b0,4'b0000,4'b0011,6'd0, 1'b0}, // 20 R10 floor
    '{1'b0,1'b1,6'd63,1'b0,1'b0,4'b0000,4'b0000,6'd63,1'b1}, // 21 R9 top
    '{1'b0,1'b0,6'd0, 1'b0,1'b0,4'b0001,4'b0000,6'd63,1'b1}, // 22 R10 ceiling
    '{1'b1,1'b0,6'd0, 1'b0,1'b0,4'b0000,4'b0000,6'd0, 1'b0}  // 23 R1 clear
  };

  task automatic check(input string tag, input logic [CW-1:0] expCnt,
                       input logic expMis);
    checks++;
    if (activityCount !== expCnt || isActive !== (expCnt != 0) ||
        countMismatch !== expMis) begin
      errors++;
      $display("FAIL %s: count=%0d active=%0b mis=%0b expected count=%0d active=%0b mis=%0b",
               tag, activityCount, isActive, countMismatch,
               expCnt, (expCnt != 0), expMis);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic [CW-1:0] p,
                       input logic m, input logic a,
                       input logic [NS-1:0] on, input logic [NS-1:0] off);
    clear = c; presetLoad = l; presetValue = p; actStrobe = m;
    advance = a; stageActivate = on; stageDeactivate = off;
    @(posedge clk); #1;
    clear = 0; presetLoad = 0; actStrobe = 0; advance = 0;
    stageActivate = '0; stageDeactivate = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 6'd0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle after reset", 6'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].clr, VEC[i].ld, VEC[i].pv, VEC[i].mk, VEC[i].adv,
            VEC[i].act, VEC[i].de);
      check($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)", i),
            VEC[i].expCnt, VEC[i].expMis);
    end

    // R3: one strobe survives exactly LAT advances
    drive(1, 0, 0, 0, 0, '0, '0);
    drive(0, 0, 0, 1, 0, '0, '0);
    check("R3 lifetime start", 6'd1, 1'b0);
    for (int k = 1; k < LAT; k++) begin
      drive(0, 0, 0, 0, 1, '0, '0);
      check($sformatf("R3 lifetime advance %0d", k), 6'd1, 1'b0);
    end
    drive(0, 0, 0, 0, 1, '0, '0);
    check("R3 lifetime end", 6'd0, 1'b0);

    // R1: asynchronous reset in the middle of activity
    drive(0, 0, 0, 1, 0, 4'b1111, '0);
    check("R5 all stages on", 6'd5, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 6'd0, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, '0, 4'b1111);
    check("R1 flags dropped by reset", 6'd0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule